// File: doc/BRIEF.md
# Time Base and Watchdog Generator

This block divides a system clock, given as a clock-enable tick, into a selectable periodic time base and a watchdog timeout flag, and presents either of them on an interrupt line. The time base and the watchdog share one counter chain. A prescaler reduces a fast source to a nominal 32 kHz reference and is bypassed when the source is a crystal. The reference feeds a counter whose tapped bit gives one of eight time-base rates. A small watchdog stage counts whole time-base periods and latches a timeout flag.

An upstream command decoder supplies single-cycle strobes. These enable or disable the time-base routing, the watchdog (which also starts or stops the shared chain) and the interrupt. Other strobes clear the timer or the watchdog and load a new 3-bit rate code. The interrupt is modelled as an open-drain pin. An output-enable says when the pin is pulled low, and a level output gives the line value that an external pull-up would produce.

Top module: `tbwd_gen`

## Requirements
- R1: After reset the interrupt is released (irq_oe_o = 0, irq_n_o = 1). The flag, the run status and the time-base level are 0, and the rate code is 3'b111.
- R2: src_sel 2'b00 (internal RC) and 2'b10 (external) divide sys_tick by 2^PRE_STAGES to form the reference tick. 2'b01 (crystal) uses every sys_tick as a reference tick. Nothing advances on a cycle without sys_tick.
- R3: With the chain running, tb_level_o is a square wave with a period of 2^(7 - code + TB_STAGES) reference ticks. It is low for the first half after a clear. Code 3'b111 is the fastest rate and 3'b000 the slowest.
- R4: After a watchdog clear, wdt_flag_o sets at the end of the 2^WDT_STAGES-th time-base period. It stays set until a watchdog clear or an interrupt disable.
- R5: The timer enable routes tb_level_o to the pin and the watchdog enable routes wdt_flag_o. Either one starts the shared chain. The pin is pulled low only while the routed source is high.
- R6: The watchdog disable stops the shared chain, so tb_level_o and wdt_flag_o hold their values.
- R7: The watchdog clear zeroes the prescaler, the chain, the watchdog stage and the flag. The timer clear zeroes only the prescaler and the chain and keeps the watchdog stage count.
- R8: The interrupt disable releases the pin and clears the flag. A later enable does not pull the pin low until a routed source goes high.
- R9: With sys_en low the counters hold for the RC and crystal sources. For the external source sys_en is ignored and counting continues.
- R10: A strobe acts on the edge where it is high and overrides a counting step on that edge. A clear issued together with an enable starts the chain from zero.
- R11: The pin is never driven high. irq_n_o is low exactly when irq_oe_o pulls it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_tick | input | 1 | System clock enable, one pulse per source period |
| sys_en | input | 1 | System running; low requests power-down |
| src_sel | input | 2 | Source: 00 RC, 01 crystal, 10 external |
| cmd_tmr_en | input | 1 | Route the time base to the pin and start the chain |
| cmd_tmr_dis | input | 1 | Remove the time-base routing |
| cmd_wdt_en | input | 1 | Route the watchdog flag to the pin and start the chain |
| cmd_wdt_dis | input | 1 | Stop the chain and remove the watchdog routing |
| cmd_irq_en | input | 1 | Enable the interrupt pin |
| cmd_irq_dis | input | 1 | Release the pin and clear the flag |
| cmd_clr_tmr | input | 1 | Clear the prescaler and the chain |
| cmd_clr_wdt | input | 1 | Clear the prescaler, the chain, the watchdog stage and the flag |
| cmd_freq_wr | input | 1 | Load freq_code |
| freq_code | input | SEL_W | Rate code, all ones is the fastest |
| irq_n_o | output | 1 | Modelled pin level with a pull-up |
| irq_oe_o | output | 1 | Pin pulled low when high |
| tb_level_o | output | 1 | Time-base square wave, debug |
| wdt_flag_o | output | 1 | Watchdog timeout flag, debug |
| run_o | output | 1 | Shared chain running, debug |

## Verification
Some rules are checked on every cycle. The flag stays set once latched, and a watchdog clear or interrupt disable takes effect on the next cycle. Outputs hold while the chain is stopped or the system is powered down, and the pin is pulled low only when a routed source is high. The directed scenarios cover what needs exact counting: the edge where the square wave changes for each source and rate code, the exact timeout edge, and the shortened timeout after a timer-only clear. They also cover the external source ignoring power-down.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;
   typedef enum logic [1:0] {
      SRC_RC   = 2'b00,
      SRC_XTAL = 2'b01,
      SRC_EXT  = 2'b10,
      SRC_RSVD = 2'b11
   } src_e;

   typedef enum logic [1:0] {
      RT_NONE = 2'b00,
      RT_TB   = 2'b01,
      RT_WDT  = 2'b10
   } route_e;
endpackage

// File: rtl/tbwd_prescale.sv
module tbwd_prescale #(
   parameter int PRE_STAGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   input  logic clr,
   input  logic bypass,
   output logic ref_tick
);
   generate
      if (PRE_STAGES == 0) begin : g_none
         logic unused_pre;
         assign unused_pre = clk ^ rst_n ^ clr ^ bypass;
         assign ref_tick   = adv;
      end else begin : g_div
         logic [PRE_STAGES-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pre_q <= '0;
            else if (clr)    pre_q <= '0;
            else if (adv)    pre_q <= pre_q + 1'b1;
         end
         assign ref_tick = adv & ~clr & (bypass | (&pre_q));
      end
   endgenerate
endmodule

// File: rtl/tbwd_chain.sv
module tbwd_chain #(
   parameter int SEL_W     = 3,
   parameter int TB_STAGES = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             run,
   input  logic             clr,
   input  logic [SEL_W-1:0] code,
   output logic             tb_level,
   output logic             period_end
);
   localparam int NSEL = (1 << SEL_W) - 1;
   localparam int CW   = NSEL + TB_STAGES;
   localparam int IW   = $clog2(CW);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] low_mask;
   logic [IW-1:0] idx;
   logic          adv;

   always_comb begin
      idx      = IW'(NSEL - int'(code) + TB_STAGES - 1);
      low_mask = (CW'(1) << (int'(idx) + 1)) - CW'(1);
   end

   assign adv        = ref_tick & run;
   assign period_end = adv & ~clr & ((cnt_q & low_mask) == low_mask);
   assign tb_level   = cnt_q[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (adv)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/tbwd_wdt.sv
module tbwd_wdt #(
   parameter int WDT_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic period_end,
   input  logic clr_stage,
   input  logic clr_flag,
   output logic flag
);
   logic [WDT_STAGES-1:0] st_q;
   logic                  flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          st_q <= '0;
      else if (clr_stage)  st_q <= '0;
      else if (period_end) st_q <= st_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  flag_q <= 1'b0;
      else if (clr_flag)                           flag_q <= 1'b0;
      else if (period_end && (&st_q) && !clr_stage) flag_q <= 1'b1;
   end

   assign flag = flag_q;
endmodule

// File: rtl/tbwd_gen.sv
module tbwd_gen
   import tbwd_pkg::*;
#(
   parameter int PRE_STAGES = 3,
   parameter int SEL_W      = 3,
   parameter int TB_STAGES  = 8,
   parameter int WDT_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sys_tick,
   input  logic             sys_en,
   input  logic [1:0]       src_sel,
   input  logic             cmd_tmr_en,
   input  logic             cmd_tmr_dis,
   input  logic             cmd_wdt_en,
   input  logic             cmd_wdt_dis,
   input  logic             cmd_irq_en,
   input  logic             cmd_irq_dis,
   input  logic             cmd_clr_tmr,
   input  logic             cmd_clr_wdt,
   input  logic             cmd_freq_wr,
   input  logic [SEL_W-1:0] freq_code,
   output logic             irq_n_o,
   output logic             irq_oe_o,
   output logic             tb_level_o,
   output logic             wdt_flag_o,
   output logic             run_o
);
   generate
      if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
         $error("tbwd_gen: SEL_W must lie in 1..4");
      end
      if (TB_STAGES < 1) begin : g_bad_tb
         $error("tbwd_gen: TB_STAGES must be at least 1");
      end
      if (WDT_STAGES < 1) begin : g_bad_wdt
         $error("tbwd_gen: WDT_STAGES must be at least 1");
      end
      if (PRE_STAGES < 0) begin : g_bad_pre
         $error("tbwd_gen: PRE_STAGES must not be negative");
      end
   endgenerate

   src_e             src;
   route_e           route_q;
   logic             run_q;
   logic             irq_en_q;
   logic [SEL_W-1:0] code_q;
   logic             active;
   logic             bypass;
   logic             ref_tick;
   logic             chain_clr;
   logic             tb_level;
   logic             period_end;
   logic             flag;

   assign src       = src_e'(src_sel);
   assign active    = sys_en | (src == SRC_EXT);
   assign bypass    = (src == SRC_XTAL);
   assign chain_clr = cmd_clr_tmr | cmd_clr_wdt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         route_q  <= RT_NONE;
         irq_en_q <= 1'b0;
         code_q   <= '1;
      end else begin
         if (cmd_wdt_dis)                     run_q <= 1'b0;
         else if (cmd_wdt_en || cmd_tmr_en)   run_q <= 1'b1;

         if (cmd_tmr_en)                                  route_q <= RT_TB;
         else if (cmd_wdt_en)                             route_q <= RT_WDT;
         else if (cmd_tmr_dis && route_q == RT_TB)        route_q <= RT_NONE;
         else if (cmd_wdt_dis && route_q == RT_WDT)       route_q <= RT_NONE;

         if (cmd_irq_dis)      irq_en_q <= 1'b0;
         else if (cmd_irq_en)  irq_en_q <= 1'b1;

         if (cmd_freq_wr)      code_q <= freq_code;
      end
   end

   tbwd_prescale #(.PRE_STAGES(PRE_STAGES)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (sys_tick & active),
      .clr      (chain_clr),
      .bypass   (bypass),
      .ref_tick (ref_tick)
   );

   tbwd_chain #(.SEL_W(SEL_W), .TB_STAGES(TB_STAGES)) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_tick   (ref_tick),
      .run        (run_q),
      .clr        (chain_clr),
      .code       (code_q),
      .tb_level   (tb_level),
      .period_end (period_end)
   );

   tbwd_wdt #(.WDT_STAGES(WDT_STAGES)) u_wdt (
      .clk        (clk),
      .rst_n      (rst_n),
      .period_end (period_end),
      .clr_stage  (cmd_clr_wdt),
      .clr_flag   (cmd_clr_wdt | cmd_irq_dis),
      .flag       (flag)
   );

   assign irq_oe_o   = irq_en_q & (((route_q == RT_TB) & tb_level) |
                                   ((route_q == RT_WDT) & flag));
   assign irq_n_o    = ~irq_oe_o;
   assign tb_level_o = tb_level;
   assign wdt_flag_o = flag;
   assign run_o      = run_q;
endmodule

// File: rtl/tbwd_gen_chk.sv
module tbwd_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sys_en,
   input logic [1:0] src_sel,
   input logic       cmd_tmr_en,
   input logic       cmd_tmr_dis,
   input logic       cmd_wdt_en,
   input logic       cmd_wdt_dis,
   input logic       cmd_irq_en,
   input logic       cmd_irq_dis,
   input logic       cmd_clr_tmr,
   input logic       cmd_clr_wdt,
   input logic       cmd_freq_wr,
   input logic       irq_oe_o,
   input logic       tb_level_o,
   input logic       wdt_flag_o,
   input logic       run_o
);
   logic any_cmd;
   assign any_cmd = cmd_tmr_en | cmd_tmr_dis | cmd_wdt_en | cmd_wdt_dis |
                    cmd_irq_en | cmd_irq_dis | cmd_clr_tmr | cmd_clr_wdt | cmd_freq_wr;

   // R4: the timeout flag is sticky
   a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_flag_o && !cmd_clr_wdt && !cmd_irq_dis) |=> wdt_flag_o);

   // R7: watchdog clear drops the flag on the next cycle
   a_r7_clr_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_clr_wdt |=> !wdt_flag_o);

   // R8: interrupt disable releases the pin
   a_r8_dis_releases: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_irq_dis |=> !irq_oe_o);

   // R5: the pin is pulled only while a source is high
   a_r5_pull_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      irq_oe_o |-> (tb_level_o || wdt_flag_o));

   // R6: a stopped chain holds its outputs
   a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_o && !any_cmd) |=> ($stable(tb_level_o) && $stable(wdt_flag_o)));

   // R9: power-down holds the counters unless the source is external
   a_r9_powerdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_en && src_sel != 2'b10 && !any_cmd) |=>
      ($stable(tb_level_o) && $stable(wdt_flag_o)));
endmodule

bind tbwd_gen tbwd_gen_chk u_chk (.*);

// File: tb/tbwd_gen_tb_top.sv
module tbwd_gen_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 50000;
   localparam logic [7:0] C_TMR_EN  = 8'h01;
   localparam logic [7:0] C_TMR_DIS = 8'h02;
   localparam logic [7:0] C_WDT_EN  = 8'h04;
   localparam logic [7:0] C_WDT_DIS = 8'h08;
   localparam logic [7:0] C_IRQ_EN  = 8'h10;
   localparam logic [7:0] C_IRQ_DIS = 8'h20;
   localparam logic [7:0] C_CLR_TMR = 8'h40;
   localparam logic [7:0] C_CLR_WDT = 8'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sys_tick = 1'b1;
   logic sys_en = 1'b1;
   logic [1:0] src_sel = 2'b00;
   logic cmd_tmr_en = 0, cmd_tmr_dis = 0, cmd_wdt_en = 0, cmd_wdt_dis = 0;
   logic cmd_irq_en = 0, cmd_irq_dis = 0, cmd_clr_tmr = 0, cmd_clr_wdt = 0;
   logic cmd_freq_wr = 0;
   logic [2:0] freq_code = 3'b111;
   logic irq_n_o, irq_oe_o, tb_level_o, wdt_flag_o, run_o;
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tbwd_gen #(.TB_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .sys_en(sys_en), .src_sel(src_sel),
      .cmd_tmr_en(cmd_tmr_en), .cmd_tmr_dis(cmd_tmr_dis), .cmd_wdt_en(cmd_wdt_en),
      .cmd_wdt_dis(cmd_wdt_dis), .cmd_irq_en(cmd_irq_en), .cmd_irq_dis(cmd_irq_dis),
      .cmd_clr_tmr(cmd_clr_tmr), .cmd_clr_wdt(cmd_clr_wdt), .cmd_freq_wr(cmd_freq_wr),
      .freq_code(freq_code), .irq_n_o(irq_n_o), .irq_oe_o(irq_oe_o),
      .tb_level_o(tb_level_o), .wdt_flag_o(wdt_flag_o), .run_o(run_o)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic step(input int k);
      repeat (k) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] m);
      {cmd_clr_wdt, cmd_clr_tmr, cmd_irq_dis, cmd_irq_en,
       cmd_wdt_dis, cmd_wdt_en, cmd_tmr_dis, cmd_tmr_en} = m;
      step(1);
      {cmd_clr_wdt, cmd_clr_tmr, cmd_irq_dis, cmd_irq_en,
       cmd_wdt_dis, cmd_wdt_en, cmd_tmr_dis, cmd_tmr_en} = '0;
   endtask

   task automatic set_freq(input logic [2:0] c);
      freq_code   = c;
      cmd_freq_wr = 1'b1;
      step(1);
      cmd_freq_wr = 1'b0;
   endtask

   task automatic t_reset;
      check("R1 oe", irq_oe_o, 1'b0);
      check("R1 pin", irq_n_o, 1'b1);
      check("R1 flag", wdt_flag_o, 1'b0);
      check("R1 run", run_o, 1'b0);
      check("R1 tb", tb_level_o, 1'b0);
   endtask

   // default rate code 111, RC source: period 32 sys ticks
   task automatic t_tb_rc;
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_TMR_EN | C_IRQ_EN);
      check("R5 run", run_o, 1'b1);
      step(15);
      check("R10 tb low E15", tb_level_o, 1'b0);
      check("R11 released", irq_n_o, 1'b1);
      step(1);
      check("R1 R3 tb high E16", tb_level_o, 1'b1);
      check("R5 oe follows tb", irq_oe_o, 1'b1);
      check("R11 pin low", irq_n_o, 1'b0);
      step(15);
      check("R3 tb high E31", tb_level_o, 1'b1);
      step(1);
      check("R3 tb low E32", tb_level_o, 1'b0);
      check("R5 oe low", irq_oe_o, 1'b0);
      cmd(C_TMR_DIS | C_IRQ_DIS);
   endtask

   task automatic t_tb_xtal;
      src_sel = 2'b01;
      cmd(C_CLR_WDT | C_TMR_EN);
      step(1);
      check("R2 xtal E1", tb_level_o, 1'b0);
      step(1);
      check("R2 xtal E2", tb_level_o, 1'b1);
      step(2);
      check("R2 xtal E4", tb_level_o, 1'b0);
   endtask

   task automatic t_freq;
      set_freq(3'b000);
      src_sel = 2'b01;
      cmd(C_CLR_WDT | C_TMR_EN);
      step(255);
      check("R3 code000 E255", tb_level_o, 1'b0);
      step(1);
      check("R3 code000 E256", tb_level_o, 1'b1);
      set_freq(3'b110);
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_TMR_EN);
      step(31);
      check("R3 code110 E31", tb_level_o, 1'b0);
      step(1);
      check("R3 code110 E32", tb_level_o, 1'b1);
      set_freq(3'b111);
   endtask

   task automatic t_wdt;
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_WDT_EN | C_IRQ_EN);
      step(16);
      check("R5 tb not routed", irq_oe_o, 1'b0);
      step(111);
      check("R4 flag E127", wdt_flag_o, 1'b0);
      step(1);
      check("R4 flag E128", wdt_flag_o, 1'b1);
      check("R5 oe flag", irq_oe_o, 1'b1);
      check("R11 pin low", irq_n_o, 1'b0);
      step(200);
      check("R4 sticky", wdt_flag_o, 1'b1);
      cmd(C_CLR_WDT);
      check("R7 flag cleared", wdt_flag_o, 1'b0);
      check("R7 pin released", irq_oe_o, 1'b0);
      step(127);
      check("R7 restart E127", wdt_flag_o, 1'b0);
      step(1);
      check("R7 restart E128", wdt_flag_o, 1'b1);
   endtask

   task automatic t_clr_tmr;
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_WDT_EN);
      step(100);
      check("R7 no flag yet", wdt_flag_o, 1'b0);
      cmd(C_CLR_TMR);
      step(31);
      check("R7 tmr clr E31", wdt_flag_o, 1'b0);
      step(1);
      check("R7 tmr clr keeps stage", wdt_flag_o, 1'b1);
   endtask

   task automatic t_wdt_dis;
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_WDT_EN);
      step(16);
      check("R6 tb high", tb_level_o, 1'b1);
      cmd(C_WDT_DIS);
      check("R6 run off", run_o, 1'b0);
      step(300);
      check("R6 tb held", tb_level_o, 1'b1);
      check("R6 no timeout", wdt_flag_o, 1'b0);
   endtask

   task automatic t_irq_dis;
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_WDT_EN | C_IRQ_EN);
      step(128);
      check("R8 pulled", irq_oe_o, 1'b1);
      cmd(C_IRQ_DIS);
      check("R8 released", irq_oe_o, 1'b0);
      check("R8 pin high", irq_n_o, 1'b1);
      check("R8 flag cleared", wdt_flag_o, 1'b0);
      cmd(C_IRQ_EN);
      check("R8 re-enable no pull", irq_oe_o, 1'b0);
      cmd(C_IRQ_DIS);
   endtask

   task automatic t_powerdown;
      src_sel = 2'b00;
      cmd(C_CLR_WDT | C_TMR_EN);
      step(16);
      check("R9 tb high", tb_level_o, 1'b1);
      sys_en = 1'b0;
      step(200);
      check("R9 rc held", tb_level_o, 1'b1);
      sys_en = 1'b1;
      sys_tick = 1'b0;
      step(200);
      check("R2 no tick held", tb_level_o, 1'b1);
      sys_tick = 1'b1;
      src_sel = 2'b10;
      sys_en = 1'b0;
      cmd(C_CLR_WDT | C_TMR_EN);
      step(15);
      check("R2 ext E15", tb_level_o, 1'b0);
      step(1);
      check("R9 ext runs", tb_level_o, 1'b1);
      sys_en = 1'b1;
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_tb_rc();
      t_tb_xtal();
      t_freq();
      t_wdt();
      t_clr_tmr();
      t_wdt_dis();
      t_irq_dis();
      t_powerdown();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule